// File: doc/BRIEF.md
# Shared Interrupt Controller

This block gathers a set of shared interrupt sources and delivers each one to a single CPU core. Every source passes through a polarity stage, then either follows its input (level mode) or latches a rising transition (edge mode). It then meets a per-source enable and a per-source routing register. Each core has one registered interrupt line and a read-only register that names the lowest-numbered source currently delivered to it.

Software programs the block over a plain 32-bit register port. The port has a valid strobe, a write flag, an 8-bit word address and write data. Read data appears one cycle after the request. Enables are never written directly: one bank of registers turns enable bits on, and a second bank turns them off. A single command register raises or removes the pending state of an edge source, so software can use edge sources as inter-processor doorbells.

Register map (word addresses):
- 0x00 identity word, read-only.
- 0x01 command register, write-only.
- 0x02/0x03 pending bits, read-only.
- 0x04/0x05 enable bits, read-only.
- 0x06/0x07 enable-set, write-only.
- 0x08/0x09 enable-clear, write-only.
- 0x0A/0x0B polarity, read/write.
- 0x0C/0x0D trigger mode, read/write.
- 0x10+c lowest delivered source for core c, read-only.
- 0x40+s route register for source s, read/write.

In each pair of word addresses, the lower address holds sources 0..31 and the upper address holds sources 32..63, with source 32·g+b at bit b.

Top module: `sic_top`

## Requirements
- R1: After reset, every source is masked (enable words read 0), active-high (polarity bits read 1 for each existing source), level-triggered (trigger words read 0), and every `cpu_irq` bit is low.
- R2: The identity word at 0x00 reads bits [7:0] = NUM_SRC/8 − 1, bits [15:8] = NUM_CPU, and all other bits 0.
- R3: Writing a word to 0x06+g sets exactly the enable bits written as 1, and writing to 0x08+g clears exactly the bits written as 1. All other enable bits keep their value. Bits for sources that do not exist read 0.
- R4: In level mode (trigger bit 0), a source's pending bit equals its input when the polarity bit is 1, and the inverted input when the polarity bit is 0.
- R5: In edge mode (trigger bit 1), a 0-to-1 change of the polarity-corrected input sets the pending bit. The bit stays set after the input returns low.
- R6: A write to 0x01 with bit 31 = 1 sets the pending bit of the edge source indexed by bits [5:0]. With bit 31 = 0, the same write clears it. The write has no effect on a level source or on an index ≥ NUM_SRC.
- R7: If a command clear and a new edge reach the same source in the same cycle, the source stays pending.
- R8: `cpu_irq[c]` rises one clock edge after some source is pending, enabled, route-valid and routed to core c.
- R9: The route register reads back as bit 31 = valid and the low bits = target core. A source is delivered to at most one core. A source with valid = 0 is delivered to none. Rewriting the target moves delivery to the new core.
- R10: Register 0x10+c reads the lowest source number delivered to core c, or 0xFFFFFFFF when none is delivered.
- R11: Read data is valid in the cycle after the read request. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_SRC | Raw source inputs, synchronous to clk |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| cpu_irq | output | NUM_CPU | One registered interrupt line per core |

## Verification
The assertions assume that `irq_in` is already synchronous to `clk`, and that at most one register access is made per cycle. Under that assumption, an enable-set and an enable-clear can never collide, and a command set and a command clear can never collide. The assertions also assume that polarity is only changed while the affected inputs are quiet, because flipping polarity under a high input counts as an edge. The stimulus drives inputs and bus signals only at falling clock edges, issues one access at a time, and flips polarity only on level sources or while edge inputs are low.

// File: rtl/sic_pkg.sv
package sic_pkg;

  localparam int SIC_MAX_SRC = 64;
  localparam int SIC_IDX_W   = 6;

  // Apply the programmed polarity: 1 keeps the input, 0 inverts it.
  function automatic logic pol_fix(input logic raw, input logic act_high);
    return act_high ? raw : ~raw;
  endfunction

  // Lowest set bit index, or all ones when the vector is empty.
  function automatic logic [31:0] first_set(input logic [SIC_MAX_SRC-1:0] v);
    logic [31:0] r;
    r = '1;
    for (int i = SIC_MAX_SRC - 1; i >= 0; i--) begin
      if (v[i]) r = 32'(i);
    end
    return r;
  endfunction

  // Identity word: source count in units of eight (minus one) and core count.
  function automatic logic [31:0] cfg_word(input int nsrc, input int ncpu);
    return {16'b0, 8'(ncpu), 8'(nsrc / 8 - 1)};
  endfunction

endpackage

// File: rtl/sic_src_bank.sv
module sic_src_bank
  import sic_pkg::*;
#(
  parameter int NUM_SRC = 40
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic [NUM_SRC-1:0] pol_q,
  input  logic [NUM_SRC-1:0] trig_q,
  input  logic [NUM_SRC-1:0] wedge_set_vec,
  input  logic [NUM_SRC-1:0] wedge_clr_vec,
  output logic [NUM_SRC-1:0] pend_vec,
  output logic [NUM_SRC-1:0] rise_vec,
  output logic [NUM_SRC-1:0] pend_edge_q
);

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    logic lvl;
    logic prev_r;
    logic edge_r;

    assign lvl = pol_fix(irq_in[s], pol_q[s]);

    // The previous level is tracked in every mode, so a change of mode
    // never shows a stale transition.
    always_ff @(posedge clk) begin
      if (!rst_n) prev_r <= 1'b0;
      else        prev_r <= lvl;
    end

    assign rise_vec[s] = lvl & ~prev_r;

    // A new edge is ORed in after the clear, so it survives a clear
    // arriving in the same cycle.
    always_ff @(posedge clk) begin
      if (!rst_n)         edge_r <= 1'b0;
      else if (trig_q[s]) edge_r <= (edge_r & ~wedge_clr_vec[s]) | wedge_set_vec[s] | rise_vec[s];
      else                edge_r <= 1'b0;
    end

    assign pend_edge_q[s] = edge_r;
    assign pend_vec[s]    = trig_q[s] ? edge_r : lvl;
  end

endmodule

// File: rtl/sic_cpu_port.sv
module sic_cpu_port
  import sic_pkg::*;
#(
  parameter int NUM_SRC = 40,
  parameter int CPU_W   = 2,
  parameter int CPU_ID  = 0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_SRC-1:0]       pend_vec,
  input  logic [NUM_SRC-1:0]       mask_q,
  input  logic [NUM_SRC-1:0]       route_valid_q,
  input  logic [NUM_SRC*CPU_W-1:0] route_cpu_flat,
  output logic                     irq_q,
  output logic [31:0]              lowest_q,
  output logic [NUM_SRC-1:0]       deliver_vec
);

  localparam logic [CPU_W-1:0] MY_ID = CPU_W'(CPU_ID);

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_sel
    assign deliver_vec[s] = pend_vec[s] & mask_q[s] & route_valid_q[s]
                          & (route_cpu_flat[s*CPU_W +: CPU_W] == MY_ID);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q    <= 1'b0;
      lowest_q <= '1;
    end else begin
      irq_q    <= |deliver_vec;
      lowest_q <= first_set(SIC_MAX_SRC'(deliver_vec));
    end
  end

endmodule

// File: rtl/sic_top.sv
module sic_top
  import sic_pkg::*;
#(
  parameter int NUM_SRC = 40,
  parameter int NUM_CPU = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic               bus_valid,
  input  logic               bus_write,
  input  logic [7:0]         bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic [NUM_CPU-1:0] cpu_irq
);

  localparam int          CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1;
  localparam logic [31:0] CFG   = cfg_word(NUM_SRC, NUM_CPU);

  // Decode
  logic       wr_en, rd_en, grp;
  logic [6:0] pair;
  assign wr_en = bus_valid & bus_write;
  assign rd_en = bus_valid & ~bus_write;
  assign grp   = bus_addr[0];
  assign pair  = bus_addr[7:1];

  logic [SIC_MAX_SRC-1:0] wr_wide, grp_wide, hot_wide;
  logic [NUM_SRC-1:0]     wr_bits, grp_bits;
  assign wr_wide  = grp ? {bus_wdata, 32'b0} : {32'b0, bus_wdata};
  assign grp_wide = grp ? {32'hFFFF_FFFF, 32'b0} : {32'b0, 32'hFFFF_FFFF};
  assign hot_wide = SIC_MAX_SRC'(1) << bus_wdata[SIC_IDX_W-1:0];
  assign wr_bits  = wr_wide[NUM_SRC-1:0];
  assign grp_bits = grp_wide[NUM_SRC-1:0];

  logic pol_wr, trig_wr, wedge_wr, route_wr;
  assign pol_wr   = wr_en && (pair == 7'h05);
  assign trig_wr  = wr_en && (pair == 7'h06);
  assign wedge_wr = wr_en && (bus_addr == 8'h01);
  assign route_wr = wr_en && (bus_addr[7:6] == 2'b01);

  // Named internal events
  logic [NUM_SRC-1:0] mask_set_vec, mask_clr_vec, wedge_set_vec, wedge_clr_vec;
  assign mask_set_vec  = (wr_en && pair == 7'h03) ? wr_bits : '0;
  assign mask_clr_vec  = (wr_en && pair == 7'h04) ? wr_bits : '0;
  assign wedge_set_vec = (wedge_wr &&  bus_wdata[31]) ? hot_wide[NUM_SRC-1:0] : '0;
  assign wedge_clr_vec = (wedge_wr && !bus_wdata[31]) ? hot_wide[NUM_SRC-1:0] : '0;

  // Configuration state
  logic [NUM_SRC-1:0] mask_q, pol_q, trig_q, route_valid_q;
  logic [CPU_W-1:0]   route_cpu_q [NUM_SRC];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      pol_q  <= '1;
      trig_q <= '0;
    end else begin
      mask_q <= (mask_q | mask_set_vec) & ~mask_clr_vec;
      if (pol_wr)  pol_q  <= (pol_q  & ~grp_bits) | wr_bits;
      if (trig_wr) trig_q <= (trig_q & ~grp_bits) | wr_bits;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      route_valid_q <= '0;
      for (int s = 0; s < NUM_SRC; s++) route_cpu_q[s] <= '0;
    end else if (route_wr) begin
      for (int s = 0; s < NUM_SRC; s++) begin
        if (bus_addr[5:0] == 6'(s)) begin
          route_valid_q[s] <= bus_wdata[31];
          route_cpu_q[s]   <= bus_wdata[CPU_W-1:0];
        end
      end
    end
  end

  logic [NUM_SRC*CPU_W-1:0] route_cpu_flat;
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_rflat
    assign route_cpu_flat[s*CPU_W +: CPU_W] = route_cpu_q[s];
  end

  // Source stage
  logic [NUM_SRC-1:0] pend_vec, rise_vec, pend_edge_q;

  sic_src_bank #(.NUM_SRC(NUM_SRC)) u_bank (
    .clk           (clk),
    .rst_n         (rst_n),
    .irq_in        (irq_in),
    .pol_q         (pol_q),
    .trig_q        (trig_q),
    .wedge_set_vec (wedge_set_vec),
    .wedge_clr_vec (wedge_clr_vec),
    .pend_vec      (pend_vec),
    .rise_vec      (rise_vec),
    .pend_edge_q   (pend_edge_q)
  );

  // Per-core delivery
  logic [NUM_CPU*32-1:0]      lowest_flat;
  logic [NUM_CPU*NUM_SRC-1:0] deliver_flat;

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    sic_cpu_port #(.NUM_SRC(NUM_SRC), .CPU_W(CPU_W), .CPU_ID(c)) u_port (
      .clk            (clk),
      .rst_n          (rst_n),
      .pend_vec       (pend_vec),
      .mask_q         (mask_q),
      .route_valid_q  (route_valid_q),
      .route_cpu_flat (route_cpu_flat),
      .irq_q          (cpu_irq[c]),
      .lowest_q       (lowest_flat[c*32 +: 32]),
      .deliver_vec    (deliver_flat[c*NUM_SRC +: NUM_SRC])
    );
  end

  // Read path
  logic [SIC_MAX_SRC-1:0] pend64, mask64, pol64, trig64;
  assign pend64 = SIC_MAX_SRC'(pend_vec);
  assign mask64 = SIC_MAX_SRC'(mask_q);
  assign pol64  = SIC_MAX_SRC'(pol_q);
  assign trig64 = SIC_MAX_SRC'(trig_q);

  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (bus_addr == 8'h00) begin
      rd_mux = CFG;
    end else if (pair == 7'h01) begin
      rd_mux = grp ? pend64[63:32] : pend64[31:0];
    end else if (pair == 7'h02) begin
      rd_mux = grp ? mask64[63:32] : mask64[31:0];
    end else if (pair == 7'h05) begin
      rd_mux = grp ? pol64[63:32] : pol64[31:0];
    end else if (pair == 7'h06) begin
      rd_mux = grp ? trig64[63:32] : trig64[31:0];
    end else if (bus_addr[7:4] == 4'h1) begin
      for (int c = 0; c < NUM_CPU; c++) begin
        if (bus_addr[3:0] == 4'(c)) rd_mux = lowest_flat[c*32 +: 32];
      end
    end else if (bus_addr[7:6] == 2'b01) begin
      for (int s = 0; s < NUM_SRC; s++) begin
        if (bus_addr[5:0] == 6'(s)) rd_mux = {route_valid_q[s], 31'(route_cpu_q[s])};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     bus_rdata <= '0;
    else if (rd_en) bus_rdata <= rd_mux;
  end

endmodule

// File: rtl/sic_checker.sv
module sic_checker #(
  parameter int NUM_SRC = 40,
  parameter int NUM_CPU = 3
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [NUM_SRC-1:0]         mask_q,
  input logic [NUM_SRC-1:0]         mask_set_vec,
  input logic [NUM_SRC-1:0]         mask_clr_vec,
  input logic [NUM_SRC-1:0]         trig_q,
  input logic [NUM_SRC-1:0]         rise_vec,
  input logic [NUM_SRC-1:0]         wedge_set_vec,
  input logic [NUM_SRC-1:0]         wedge_clr_vec,
  input logic [NUM_SRC-1:0]         pend_edge_q,
  input logic [NUM_SRC-1:0]         route_valid_q,
  input logic [NUM_CPU*NUM_SRC-1:0] deliver_flat,
  input logic [NUM_CPU*32-1:0]      lowest_flat,
  input logic [NUM_CPU-1:0]         cpu_irq
);

  p_mask_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|mask_set_vec) |=> ((mask_q & $past(mask_set_vec)) == $past(mask_set_vec)));

  p_mask_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|mask_clr_vec) |=> ((mask_q & $past(mask_clr_vec)) == '0));

  p_mask_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|mask_set_vec) && !(|mask_clr_vec)) |=> $stable(mask_q));

  p_edge_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(rise_vec & trig_q)) |=>
      ((pend_edge_q & $past(rise_vec & trig_q)) == $past(rise_vec & trig_q)));

  p_wedge_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(wedge_clr_vec & ~rise_vec)) |=>
      ((pend_edge_q & $past(wedge_clr_vec & ~rise_vec)) == '0));

  p_wedge_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(wedge_set_vec & ~trig_q)) |=>
      ((pend_edge_q & $past(wedge_set_vec & ~trig_q)) == '0));

  p_edge_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(wedge_clr_vec & rise_vec & trig_q)) |=>
      ((pend_edge_q & $past(wedge_clr_vec & rise_vec & trig_q))
        == $past(wedge_clr_vec & rise_vec & trig_q)));

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_s
    logic [NUM_CPU-1:0] col;
    for (genvar c = 0; c < NUM_CPU; c++) begin : g_c
      assign col[c] = deliver_flat[c*NUM_SRC + s];
    end

    p_one_target_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(col));

    p_valid_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (|col) |-> route_valid_q[s]);
  end

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    p_lowest_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_irq[c] |-> (lowest_flat[c*32 +: 32] == 32'hFFFF_FFFF));

    p_lowest_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_irq[c] |-> (lowest_flat[c*32 +: 32] < 32'(NUM_SRC)));
  end

endmodule

bind sic_top sic_checker #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .mask_q        (mask_q),
  .mask_set_vec  (mask_set_vec),
  .mask_clr_vec  (mask_clr_vec),
  .trig_q        (trig_q),
  .rise_vec      (rise_vec),
  .wedge_set_vec (wedge_set_vec),
  .wedge_clr_vec (wedge_clr_vec),
  .pend_edge_q   (pend_edge_q),
  .route_valid_q (route_valid_q),
  .deliver_flat  (deliver_flat),
  .lowest_flat   (lowest_flat),
  .cpu_irq       (cpu_irq)
);

// File: tb/tb_sic_top.sv
module tb_sic_top;

  localparam int NUM_SRC = 40;
  localparam int NUM_CPU = 3;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [NUM_SRC-1:0] irq_in = '0;
  logic               bus_valid = 1'b0;
  logic               bus_write = 1'b0;
  logic [7:0]         bus_addr = '0;
  logic [31:0]        bus_wdata = '0;
  logic [31:0]        bus_rdata;
  logic [NUM_CPU-1:0] cpu_irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  sic_top #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_in    (irq_in),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cpu_irq   (cpu_irq)
  );

  // Level/polarity table: {source[5:0], polarity, raw input, expected pending}
  localparam logic [8:0] LVL_TAB [8] = '{
    {6'd0,  1'b1, 1'b1, 1'b1},
    {6'd0,  1'b1, 1'b0, 1'b0},
    {6'd5,  1'b0, 1'b0, 1'b1},
    {6'd5,  1'b0, 1'b1, 1'b0},
    {6'd33, 1'b1, 1'b1, 1'b1},
    {6'd33, 1'b0, 1'b1, 1'b0},
    {6'd39, 1'b0, 1'b0, 1'b1},
    {6'd39, 1'b0, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    d = bus_rdata;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state
    chk("R1 cpu_irq", 32'(cpu_irq), 32'h0);
    rd(8'h04, d); chk("R1 mask0", d, 32'h0);
    rd(8'h05, d); chk("R1 mask1", d, 32'h0);
    rd(8'h0A, d); chk("R1 pol0", d, 32'hFFFF_FFFF);
    rd(8'h0B, d); chk("R1 pol1", d, 32'h0000_00FF);
    rd(8'h0C, d); chk("R1 trig0", d, 32'h0);
    rd(8'h0D, d); chk("R1 trig1", d, 32'h0);
    rd(8'h00, d); chk("R2 identity", d, 32'h0000_0304);
    rd(8'h10, d); chk("R10 lowest idle", d, 32'hFFFF_FFFF);

    // R4 table walk
    for (int i = 0; i < 8; i++) begin
      int src, g, b;
      logic pol, raw, ex;
      src = int'(LVL_TAB[i][8:3]);
      pol = LVL_TAB[i][2];
      raw = LVL_TAB[i][1];
      ex  = LVL_TAB[i][0];
      g = src / 32;
      b = src % 32;
      wr(8'h0A + 8'(g), pol ? 32'hFFFF_FFFF : ~(32'h1 << b));
      irq_in = '0;
      irq_in[src] = raw;
      rd(8'h02 + 8'(g), d);
      chk("R4 level pending", 32'(d[b]), 32'(ex));
    end
    irq_in = '0;
    wr(8'h0A, 32'hFFFF_FFFF);
    wr(8'h0B, 32'hFFFF_FFFF);

    // R3 enable set/clear
    wr(8'h06, 32'h0000_00F0); rd(8'h04, d); chk("R3 set", d, 32'h0000_00F0);
    wr(8'h06, 32'h0000_000F); rd(8'h04, d); chk("R3 set keeps", d, 32'h0000_00FF);
    wr(8'h08, 32'h0000_0030); rd(8'h04, d); chk("R3 clear", d, 32'h0000_00CF);
    wr(8'h07, 32'h0000_0081); rd(8'h05, d); chk("R3 upper set", d, 32'h0000_0081);
    rd(8'h04, d); chk("R3 lower untouched", d, 32'h0000_00CF);
    wr(8'h07, 32'hFFFF_FFFF); rd(8'h05, d); chk("R3 absent bits", d, 32'h0000_00FF);
    wr(8'h08, 32'hFFFF_FFFF); wr(8'h09, 32'hFFFF_FFFF);
    rd(8'h04, d); chk("R3 clear all", d, 32'h0);

    // R8 delivery of level sources to core 1
    wr(8'h43, 32'h8000_0001);
    wr(8'h41, 32'h8000_0001);
    wr(8'h06, 32'h0000_000A);
    @(negedge clk); irq_in[3] = 1'b1;
    @(negedge clk); chk("R8 one edge latency", 32'(cpu_irq), 32'h2);
    rd(8'h11, d); chk("R10 lowest 3", d, 32'd3);
    irq_in[1] = 1'b1;
    repeat (2) @(negedge clk);
    rd(8'h11, d); chk("R10 lowest 1", d, 32'd1);

    // R9 reroute and valid gating
    wr(8'h43, 32'h8000_0002);
    @(negedge clk); chk("R9 moved", 32'(cpu_irq), 32'h6);
    rd(8'h43, d); chk("R9 readback", d, 32'h8000_0002);
    wr(8'h41, 32'h0000_0001);
    @(negedge clk); chk("R9 invalid route", 32'(cpu_irq), 32'h4);
    rd(8'h11, d); chk("R10 emptied", d, 32'hFFFF_FFFF);
    irq_in = '0;
    repeat (2) @(negedge clk);
    chk("R8 drop", 32'(cpu_irq), 32'h0);

    // R5 edge source 34 to core 0
    wr(8'h0D, 32'h0000_0004);
    wr(8'h62, 32'h8000_0000);
    wr(8'h07, 32'h0000_0004);
    @(negedge clk); irq_in[34] = 1'b1;
    @(negedge clk); irq_in[34] = 1'b0;
    repeat (2) @(negedge clk);
    chk("R5 edge held", 32'(cpu_irq), 32'h1);
    rd(8'h03, d); chk("R5 pending", d, 32'h0000_0004);
    rd(8'h10, d); chk("R10 lowest 34", d, 32'd34);

    // R6 command clear / set
    wr(8'h01, 32'd34);
    @(negedge clk); chk("R6 clear", 32'(cpu_irq), 32'h0);
    rd(8'h03, d); chk("R6 clear pending", d, 32'h0);
    wr(8'h01, 32'h8000_0022);
    @(negedge clk); chk("R6 set", 32'(cpu_irq), 32'h1);
    wr(8'h01, 32'd34);

    // R6 ignored on a level source and out-of-range index
    wr(8'h45, 32'h8000_0000);
    wr(8'h06, 32'h0000_0020);
    wr(8'h01, 32'h8000_0005);
    rd(8'h02, d); chk("R6 level ignores", d, 32'h0);
    chk("R6 level no irq", 32'(cpu_irq), 32'h0);
    wr(8'h01, 32'h8000_002D);
    rd(8'h02, d); chk("R6 range lo", d, 32'h0);
    rd(8'h03, d); chk("R6 range hi", d, 32'h0);

    // R7 clear and new edge together
    wr(8'h01, 32'h8000_0022);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 8'h01; bus_wdata = 32'd34;
    irq_in[34] = 1'b1;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    rd(8'h03, d); chk("R7 edge wins", d, 32'h0000_0004);
    irq_in[34] = 1'b0;
    wr(8'h01, 32'd34);
    rd(8'h03, d); chk("R7 then cleared", d, 32'h0);

    // R11 unmapped read
    rd(8'h30, d); chk("R11 unmapped", d, 32'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule